// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block sits between two interrupt sources and a CPU's interrupt controller. One source is an external pin, which is brought into the clock domain through a synchronizer. The other is the ready indication of a serial receiver. Each source has its own select bit that picks one of two modes. In edge mode a rising edge sets a sticky request flag. In level mode the request output simply follows the source level.

The pin flag can be cleared by software through a clear-command write whose data byte names the source. The receiver flag is cleared only by a read strobe of the receive buffer. Changing a mode has side effects on the flags, and these side effects are part of the contract.

The CPU side uses two strobes. An acknowledge strobe records which source is being serviced. A later vector-read strobe returns that source's vector. If the request has disappeared between the two strobes, the vector read returns a fixed default vector instead.

Top module: `irq_latch`

## Requirements
- R1: After reset both flags are zero, both sources are in edge mode, `irq_pin`, `irq_rx`, `irq_any` and `vec_valid` are low and `vec_out` is zero.
- R2: In pin edge mode, a rising pin edge sets the pin flag. The edge is seen after a two-stage synchronizer and compared with a registered previous value. The flag then holds `irq_pin` high after the pin returns low.
- R3: A clear write with `clr_data` = 0x0A clears the pin flag. A clear write with any other data value leaves the pin flag unchanged.
- R4: In pin edge mode, a rising edge and a clear in the same cycle leave the pin flag set.
- R5: In pin level mode, `irq_pin` equals the synchronized pin level, so a high-to-low pin change withdraws the request.
- R6: A `cfg_we` write that moves the pin from edge mode to level mode (`cfg_data[0]` = 1) clears the pin flag in that same write.
- R7: A write that moves the pin from level mode back to edge mode (`cfg_data[0]` = 0) keeps a flag that was set in level mode. An explicit clear write is then needed to remove it.
- R8: In receiver edge mode, a rising edge of `rx_ready` sets the receiver flag. Only `rx_buf_rd` or reset clears it. Clear writes of any value have no effect on it.
- R9: In receiver level mode (`cfg_data[1]` = 1), `irq_rx` follows `rx_ready` directly.
- R10: `ack` records the pin source if `irq_pin` is high, otherwise the receiver source if `irq_rx` is high. A following `vec_rd` returns 0x0028 for the pin and 0x0050 for the receiver while that request is still active. A vector read of the pin in edge mode clears the pin flag. A vector read of the receiver leaves the receiver flag set.
- R11: `vec_rd` returns the default vector 0x0004 in two cases: the recorded request is no longer active, or no source was recorded.
- R12: `vec_valid` is a one-cycle pulse in the cycle after `vec_rd`, and `vec_out` then holds a legal vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| rx_ready | input | 1 | Receiver data-ready level, synchronous to clk |
| rx_buf_rd | input | 1 | Receive-buffer read strobe |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_data | input | 2 | Bit 0: pin level mode; bit 1: receiver level mode (1 = level) |
| clr_we | input | 1 | Clear-command write strobe |
| clr_data | input | 8 | Clear-command code; 0x0A selects the pin source |
| ack | input | 1 | Interrupt acknowledge strobe |
| vec_rd | input | 1 | Vector-read strobe |
| irq_pin | output | 1 | Pin interrupt request |
| irq_rx | output | 1 | Receiver interrupt request |
| irq_any | output | 1 | OR of both requests |
| vec_out | output | 16 | Vector returned by the last vector read |
| vec_valid | output | 1 | One-cycle pulse marking a new `vec_out` |

## Verification
The assertions take three things for granted. First, `rx_ready`, `rx_buf_rd` and all CPU-side strobes are synchronous to `clk`; only `pin_in` may be asynchronous. Second, `ack` and `vec_rd` never arrive in the same cycle. Third, a mode write and a clear write for the pin do not arrive together when a flag outcome is under test. The stimulus drives every input on the falling clock edge, so inputs are stable at the sampling edge. It keeps each strobe to one cycle and sends acknowledge, clear and vector-read strobes in separate cycles. The set-over-clear case is hit by timing a clear write to land exactly on the cycle in which the synchronized rising edge becomes visible.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Source recorded at acknowledge time
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PIN  = 2'd1,
        SRC_RX   = 2'd2
    } irq_src_e;

endpackage

// File: rtl/irq_edge_sync.sv
// Synchronizer chain plus previous-value register; yields level and rise.
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.chain[LAST];
    assign rise = st_q.chain[LAST] & ~st_q.prev;

endmodule

// File: rtl/irq_pin_flag.sv
// Pin request flag with mode bit and mode-switch side effects.
module irq_pin_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise,
    input  logic mode_we,
    input  logic mode_wdata,
    input  logic clr_hit,
    input  logic vec_clr,
    output logic flag,
    output logic mode
);
    typedef struct packed {
        logic flag;
        logic mode;
    } pin_state_t;

    pin_state_t st_q, st_d;
    logic       set_req;
    logic       clr_req;
    logic       to_level;

    always_comb begin
        st_d     = st_q;
        to_level = mode_we & mode_wdata & ~st_q.mode;
        set_req  = st_q.mode ? lvl : rise;
        clr_req  = clr_hit | (vec_clr & ~st_q.mode) | to_level;
        if (set_req) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
        if (mode_we) begin
            st_d.mode = mode_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign mode = st_q.mode;

endmodule

// File: rtl/irq_rx_flag.sv
// Receiver request flag: set on ready rise, cleared only by buffer read.
module irq_rx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic buf_rd,
    input  logic mode_we,
    input  logic mode_wdata,
    output logic flag,
    output logic mode
);
    typedef struct packed {
        logic flag;
        logic mode;
        logic prev;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      set_req;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ready;
        set_req   = st_q.mode ? ready : (ready & ~st_q.prev);
        if (set_req) begin
            st_d.flag = 1'b1;
        end else if (buf_rd) begin
            st_d.flag = 1'b0;
        end
        if (mode_we) begin
            st_d.mode = mode_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign mode = st_q.mode;

endmodule

// File: rtl/irq_vec_unit.sv
// Records the acknowledged source and answers the vector read.
module irq_vec_unit
    import irq_latch_pkg::*;
#(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] PIN_VEC = 'h28,
    parameter logic [VEC_W-1:0] RX_VEC  = 'h50,
    parameter logic [VEC_W-1:0] DEF_VEC = 'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             vec_rd,
    input  logic             req_pin,
    input  logic             req_rx,
    output logic             pin_vec_clr,
    output logic [VEC_W-1:0] vec,
    output logic             vec_valid
);
    typedef struct packed {
        irq_src_e         acc;
        logic [VEC_W-1:0] vec;
        logic             valid;
    } vec_state_t;

    vec_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        pin_vec_clr = 1'b0;
        if (ack) begin
            if (req_pin) begin
                st_d.acc = SRC_PIN;
            end else if (req_rx) begin
                st_d.acc = SRC_RX;
            end else begin
                st_d.acc = SRC_NONE;
            end
        end
        if (vec_rd) begin
            st_d.valid = 1'b1;
            st_d.acc   = SRC_NONE;
            if (st_q.acc == SRC_PIN && req_pin) begin
                st_d.vec    = PIN_VEC;
                pin_vec_clr = 1'b1;
            end else if (st_q.acc == SRC_RX && req_rx) begin
                st_d.vec = RX_VEC;
            end else begin
                st_d.vec = DEF_VEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{acc: SRC_NONE, vec: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vec       = st_q.vec;
    assign vec_valid = st_q.valid;

endmodule

// File: rtl/irq_latch.sv
// Top: two interrupt sources with edge/level selection and vector fallback.
module irq_latch #(
    parameter int               SYNC_STAGES  = 2,
    parameter int               CLR_W        = 8,
    parameter logic [CLR_W-1:0] PIN_CLR_CODE = 'h0A,
    parameter int               VEC_W        = 16,
    parameter logic [VEC_W-1:0] PIN_VEC      = 'h28,
    parameter logic [VEC_W-1:0] RX_VEC       = 'h50,
    parameter logic [VEC_W-1:0] DEF_VEC      = 'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             rx_ready,
    input  logic             rx_buf_rd,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_data,
    input  logic             clr_we,
    input  logic [CLR_W-1:0] clr_data,
    input  logic             ack,
    input  logic             vec_rd,
    output logic             irq_pin,
    output logic             irq_rx,
    output logic             irq_any,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    logic pin_lvl;
    logic pin_rise;
    logic pin_flag;
    logic pin_mode;
    logic rx_flag;
    logic rx_mode;
    logic clr_hit;
    logic pin_vec_clr;

    assign clr_hit = clr_we && (clr_data == PIN_CLR_CODE);

    irq_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .lvl      (pin_lvl),
        .rise     (pin_rise)
    );

    irq_pin_flag u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (pin_lvl),
        .rise       (pin_rise),
        .mode_we    (cfg_we),
        .mode_wdata (cfg_data[0]),
        .clr_hit    (clr_hit),
        .vec_clr    (pin_vec_clr),
        .flag       (pin_flag),
        .mode       (pin_mode)
    );

    irq_rx_flag u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (rx_ready),
        .buf_rd     (rx_buf_rd),
        .mode_we    (cfg_we),
        .mode_wdata (cfg_data[1]),
        .flag       (rx_flag),
        .mode       (rx_mode)
    );

    // Level mode bypasses the stored flag
    assign irq_pin = pin_mode ? pin_lvl  : pin_flag;
    assign irq_rx  = rx_mode  ? rx_ready : rx_flag;
    assign irq_any = irq_pin | irq_rx;

    irq_vec_unit #(
        .VEC_W   (VEC_W),
        .PIN_VEC (PIN_VEC),
        .RX_VEC  (RX_VEC),
        .DEF_VEC (DEF_VEC)
    ) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack         (ack),
        .vec_rd      (vec_rd),
        .req_pin     (irq_pin),
        .req_rx      (irq_rx),
        .pin_vec_clr (pin_vec_clr),
        .vec         (vec_out),
        .vec_valid   (vec_valid)
    );

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] PIN_VEC = 'h28,
    parameter logic [VEC_W-1:0] RX_VEC  = 'h50,
    parameter logic [VEC_W-1:0] DEF_VEC = 'h04
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_mode,
    input logic             pin_flag,
    input logic             pin_rise,
    input logic             rx_mode,
    input logic             irq_pin,
    input logic             irq_rx,
    input logic             rx_ready,
    input logic             rx_buf_rd,
    input logic             cfg_we,
    input logic [1:0]       cfg_data,
    input logic             clr_hit,
    input logic             vec_rd,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out
);
    AST_PIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && clr_hit && !pin_rise && !cfg_we) |=> !irq_pin); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && pin_rise) |=> pin_flag); // R4

    AST_EDGE_TO_LEVEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && cfg_we && cfg_data[0] && !pin_rise) |=> !pin_flag); // R6

    AST_LEVEL_TO_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && pin_flag && cfg_we && !cfg_data[0] && !clr_hit) |=> irq_pin); // R7

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && irq_rx && !rx_buf_rd && !cfg_we) |=> irq_rx); // R8

    AST_RX_BUF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && rx_buf_rd && !rx_ready && !cfg_we) |=> !irq_rx); // R8

    AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(vec_rd)); // R12

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out == PIN_VEC || vec_out == RX_VEC || vec_out == DEF_VEC)); // R11

endmodule

bind irq_latch irq_latch_chk #(
    .VEC_W   (VEC_W),
    .PIN_VEC (PIN_VEC),
    .RX_VEC  (RX_VEC),
    .DEF_VEC (DEF_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_mode  (pin_mode),
    .pin_flag  (pin_flag),
    .pin_rise  (pin_rise),
    .rx_mode   (rx_mode),
    .irq_pin   (irq_pin),
    .irq_rx    (irq_rx),
    .rx_ready  (rx_ready),
    .rx_buf_rd (rx_buf_rd),
    .cfg_we    (cfg_we),
    .cfg_data  (cfg_data),
    .clr_hit   (clr_hit),
    .vec_rd    (vec_rd),
    .vec_valid (vec_valid),
    .vec_out   (vec_out)
);

// File: tb/irq_latch_bench.sv
module irq_latch_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] V_PIN = 16'h0028;
    localparam logic [15:0] V_RX  = 16'h0050;
    localparam logic [15:0] V_DEF = 16'h0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        rx_ready = 1'b0;
    logic        rx_buf_rd = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_data = 2'b00;
    logic        clr_we = 1'b0;
    logic [7:0]  clr_data = 8'h00;
    logic        ack = 1'b0;
    logic        vec_rd = 1'b0;
    logic        irq_pin;
    logic        irq_rx;
    logic        irq_any;
    logic [15:0] vec_out;
    logic        vec_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_latch u_irq_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .rx_ready  (rx_ready),
        .rx_buf_rd (rx_buf_rd),
        .cfg_we    (cfg_we),
        .cfg_data  (cfg_data),
        .clr_we    (clr_we),
        .clr_data  (clr_data),
        .ack       (ack),
        .vec_rd    (vec_rd),
        .irq_pin   (irq_pin),
        .irq_rx    (irq_rx),
        .irq_any   (irq_any),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] d);
        cfg_we = 1'b1; cfg_data = d; tick(1); cfg_we = 1'b0;
    endtask

    task automatic clr_write(input logic [7:0] d);
        clr_we = 1'b1; clr_data = d; tick(1); clr_we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic pulse_buf_rd();
        rx_buf_rd = 1'b1; tick(1); rx_buf_rd = 1'b0;
    endtask

    task automatic pin_pulse();
        pin_in = 1'b1; tick(4); pin_in = 1'b0; tick(4);
    endtask

    // Driver: queue the expected vector and issue the read strobe
    task automatic read_vector(input logic [15:0] exp);
        exp_q.push_back(exp);
        vec_rd = 1'b1; tick(1); vec_rd = 1'b0;
    endtask

    // Monitor: pop and compare each vector the design returns (R10, R11)
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected vector", vec_out, 16'hFFFF);
            end else begin
                check("R10/R11 vector", vec_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 irq_pin", {15'd0, irq_pin}, 16'd0);
        check("R1 irq_rx", {15'd0, irq_rx}, 16'd0);
        check("R1 irq_any", {15'd0, irq_any}, 16'd0);
        check("R1 vec_valid", {15'd0, vec_valid}, 16'd0);
        check("R1 vec_out", vec_out, 16'd0);

        // R2 edge capture, held after pin falls
        pin_in = 1'b1; tick(4);
        check("R2 set on edge", {15'd0, irq_pin}, 16'd1);
        pin_in = 1'b0; tick(4);
        check("R2 held after fall", {15'd0, irq_pin}, 16'd1);

        // R10 pin vector, clears pin flag; R12 pulse
        pulse_ack();
        read_vector(V_PIN);
        tick(1);
        check("R10 pin flag cleared by vector read", {15'd0, irq_pin}, 16'd0);
        check("R12 vec_valid single pulse", {15'd0, vec_valid}, 16'd0);

        // R3 clear codes
        pin_pulse();
        clr_write(8'h0B);
        check("R3 other code ignored", {15'd0, irq_pin}, 16'd1);
        clr_write(8'h0A);
        check("R3 pin clear", {15'd0, irq_pin}, 16'd0);

        // R11 vanished request and no acknowledge
        pin_pulse();
        pulse_ack();
        clr_write(8'h0A);
        read_vector(V_DEF);
        tick(1);
        read_vector(V_DEF);
        tick(1);

        // R4 clear lands on the rising-edge cycle
        pin_in = 1'b1; tick(2);
        clr_we = 1'b1; clr_data = 8'h0A; tick(1); clr_we = 1'b0;
        check("R4 set wins over clear", {15'd0, irq_pin}, 16'd1);
        pin_in = 1'b0; tick(3);
        clr_write(8'h0A);

        // R6 edge-to-level clears
        pin_pulse();
        cfg_write(2'b01);
        check("R6 level mode after switch", {15'd0, irq_pin}, 16'd0);
        cfg_write(2'b00);
        check("R6 flag was cleared", {15'd0, irq_pin}, 16'd0);

        // R5 level follow, R7 level-to-edge keeps
        cfg_write(2'b01);
        pin_in = 1'b1; tick(3);
        check("R5 level high", {15'd0, irq_pin}, 16'd1);
        pin_in = 1'b0; tick(3);
        check("R5 level withdrawn", {15'd0, irq_pin}, 16'd0);
        cfg_write(2'b00);
        check("R7 flag kept", {15'd0, irq_pin}, 16'd1);
        clr_write(8'h0A);
        check("R7 explicit clear", {15'd0, irq_pin}, 16'd0);

        // R8 receiver edge flag
        rx_ready = 1'b1; tick(2);
        check("R8 rx set", {15'd0, irq_rx}, 16'd1);
        clr_write(8'h0A);
        clr_write(8'h0B);
        check("R8 clear writes ignored", {15'd0, irq_rx}, 16'd1);
        rx_ready = 1'b0; tick(2);
        check("R8 held after ready falls", {15'd0, irq_rx}, 16'd1);
        pulse_buf_rd();
        check("R8 buffer read clears", {15'd0, irq_rx}, 16'd0);

        // R10 priority and receiver vector
        rx_ready = 1'b1; tick(2); rx_ready = 1'b0;
        pin_pulse();
        pulse_ack();
        read_vector(V_PIN);
        pulse_ack();
        read_vector(V_RX);
        tick(1);
        check("R10 rx flag kept after vector read", {15'd0, irq_rx}, 16'd1);
        pulse_buf_rd();
        rx_ready = 1'b1; tick(2); rx_ready = 1'b0;
        pulse_ack();
        pulse_buf_rd();
        read_vector(V_DEF);
        tick(1);

        // R9 receiver level mode
        cfg_write(2'b10);
        rx_ready = 1'b1; tick(1);
        check("R9 rx level high", {15'd0, irq_rx}, 16'd1);
        rx_ready = 1'b0; tick(1);
        check("R9 rx level low", {15'd0, irq_rx}, 16'd0);

        tick(3);
        check("R12 all vectors returned", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule